// File: doc/BRIEF.md
# Dual-Level LED PWM Dimmer

This block drives four LED pins. Each pin has its own 8-bit brightness that sets a fast pulse-width waveform. A second, slower pulse-width waveform is shared by all pins and scales their brightness together. A 2-bit mode per pin chooses the source for that pin:

- held low,
- held high,
- the pin's own fast waveform alone,
- the fast waveform ANDed with the slow group waveform.

An active-low enable input decides whether the pins show that source. When the input is inactive, a 2-bit policy and a drive-type bit set what the pins show instead. Each pin is presented as a data bit plus a drive-enable bit, so that the high-impedance state can be modelled.

Registers are loaded through a single-cycle parallel write port. A staging bit defers brightness, group-duty and mode writes until a STOP strobe. The STOP strobe comes from the surrounding bus logic. Deferring the writes lets several dimmers change their outputs on the same cycle.

Top module: `led_dual_dimmer`

## Requirements
- R1: After reset, every brightness value is 00h, the group duty is FFh, every pin is in mode 00 (held low), staging is off, the group gate is in use, the off policy is 00 and the drive type is 0. With `oeN` low, all pins therefore show data 0 with enable 1.
- R2: Write addresses are as follows:
  - 0 is the control register: bit0 staging, bit1 group bypass, bits[3:2] off policy, bit4 drive type.
  - 1 to 4 are the brightness of pins 0 to 3.
  - 5 is the group duty.
  - 6 is the group frequency. It is accepted and discarded.
  - 7 is the mode register, with pin n's mode in bits [2n+1:2n].
- R3: The fast step counter advances once every FAST_DIV clocks and wraps after 256 steps. In mode 10 a pin is high while the step count is below its brightness. Over any 256*FAST_DIV-clock window its high time is therefore brightness*FAST_DIV clocks: 00h never goes high, and FFh is low for exactly one step.
- R4: The group counter advances once every GRP_PRE fast steps and wraps after 256 steps. In mode 11 a pin is high only while its fast waveform is high and the group count is below the group duty. A group duty of 00h keeps such pins low.
- R5: Mode 00 holds the pin's data at 0, and mode 01 holds it at 1, without any pulsing.
- R6: With group bypass set, mode 11 behaves exactly as mode 10. Writes to address 6 never change any output.
- R7: While `oeN` is low, every pin is enabled and shows its source. While `oeN` is high, the pins show the off policy:
  - policy 00 gives enable 1 and data 0;
  - policy 01 gives enable 1 and data 1 when the drive type is 1, and enable 0 and data 0 when the drive type is 0;
  - policy 10 gives enable 0 and data 0;
  - the reserved policy 11 behaves as 10.
- R8: With staging on, writes to addresses 1 to 5 and 7 are held and do not change any output. A STOP strobe makes all held values take effect together on the next cycle.
- R9: Control-register writes take effect on the next cycle even while staging is on.
- R10: With staging off, brightness, group and mode writes take effect on the next cycle. A STOP strobe with nothing pending changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| stopStrobe | input | 1 | Bus STOP event, one clock wide |
| oeN | input | 1 | Active-low output enable |
| ledData | output | 4 | Pin data value, one bit per LED |
| ledEn | output | 4 | Pin drive enable, 0 meaning high impedance |

## Verification
Pin outputs are combinational decodes of the counters and the active registers, so a corrupted counter or register shows on the pins in the same cycle. A step counter off by one appears as a high time one step too long or too short within the first fast period. A pending write that leaks into the active registers too early changes the pin waveform within one fast period of the write, before any STOP strobe. A fault in the off policy decode appears the moment `oeN` rises.

// File: rtl/led_dimmer_pkg.sv
package led_dimmer_pkg;

  localparam int LED_CH = 4;
  localparam int DUTY_W = 8;
  localparam int MODE_W = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DUTY0 = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_GRP   = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_GFREQ = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd7;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF = 2'b00,
    MODE_ON  = 2'b01,
    MODE_IND = 2'b10,
    MODE_GRP = 2'b11
  } led_mode_e;

  typedef enum logic [1:0] {
    POL_LOW   = 2'b00,
    POL_HIORZ = 2'b01,
    POL_Z     = 2'b10,
    POL_RSVD  = 2'b11
  } off_pol_e;

  typedef struct packed {
    logic [LED_CH-1:0][DUTY_W-1:0] duty;
    logic [DUTY_W-1:0]             grpDuty;
    logic [LED_CH-1:0][MODE_W-1:0] mode;
    logic                          stageOnStop;
    logic                          grpBypass;
    off_pol_e                      offPolicy;
    logic                          driveHigh;
  } cfg_t;

  typedef struct packed {
    logic fastTick;
    logic grpTick;
  } tick_t;

endpackage

// File: rtl/led_dimmer_ctrl.sv
module led_dimmer_ctrl
  import led_dimmer_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int GRP_PRE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DUTY_W-1:0] wrData,
  input  logic              stopStrobe,
  output cfg_t              cfg,
  output tick_t             ticks
);

  localparam int FD_W = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam int GP_W = (GRP_PRE > 1) ? $clog2(GRP_PRE) : 1;

  // tick generation
  logic [FD_W-1:0] fastDivCnt;
  logic [GP_W-1:0] grpPreCnt;
  logic fastTick, grpTick;

  assign fastTick = (fastDivCnt == FD_W'(FAST_DIV - 1));
  assign grpTick  = fastTick && (grpPreCnt == GP_W'(GRP_PRE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastDivCnt <= '0;
      grpPreCnt  <= '0;
    end else begin
      fastDivCnt <= fastTick ? '0 : fastDivCnt + 1'b1;
      if (fastTick) grpPreCnt <= grpTick ? '0 : grpPreCnt + 1'b1;
    end
  end

  assign ticks.fastTick = fastTick;
  assign ticks.grpTick  = grpTick;

  // register file: shadow copies follow writes, active copies drive pins
  logic [DUTY_W-1:0]             shdDuty [LED_CH];
  logic [DUTY_W-1:0]             actDuty [LED_CH];
  logic [DUTY_W-1:0]             shdGrp, actGrp;
  logic [LED_CH*MODE_W-1:0]      shdMode, actMode;
  logic                          stageOnStop, grpBypass, driveHigh;
  off_pol_e                      offPolicy;

  logic [LED_CH-1:0] dutyWr;
  logic ctrlWr, grpWr, modeWr;

  always_comb begin
    for (int i = 0; i < LED_CH; i++)
      dutyWr[i] = wrEn && (wrAddr == ADR_DUTY0 + ADDR_W'(i));
  end
  assign ctrlWr = wrEn && (wrAddr == ADR_CTRL);
  assign grpWr  = wrEn && (wrAddr == ADR_GRP);
  assign modeWr = wrEn && (wrAddr == ADR_MODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LED_CH; i++) begin
        shdDuty[i] <= '0;
        actDuty[i] <= '0;
      end
      shdGrp      <= '1;
      actGrp      <= '1;
      shdMode     <= '0;
      actMode     <= '0;
      stageOnStop <= 1'b0;
      grpBypass   <= 1'b0;
      offPolicy   <= POL_LOW;
      driveHigh   <= 1'b0;
    end else begin
      if (stopStrobe) begin
        for (int i = 0; i < LED_CH; i++) actDuty[i] <= shdDuty[i];
        actGrp  <= shdGrp;
        actMode <= shdMode;
      end
      for (int i = 0; i < LED_CH; i++) begin
        if (dutyWr[i]) begin
          shdDuty[i] <= wrData;
          if (!stageOnStop) actDuty[i] <= wrData;
        end
      end
      if (grpWr) begin
        shdGrp <= wrData;
        if (!stageOnStop) actGrp <= wrData;
      end
      if (modeWr) begin
        shdMode <= wrData[LED_CH*MODE_W-1:0];
        if (!stageOnStop) actMode <= wrData[LED_CH*MODE_W-1:0];
      end
      if (ctrlWr) begin
        stageOnStop <= wrData[0];
        grpBypass   <= wrData[1];
        offPolicy   <= off_pol_e'(wrData[3:2]);
        driveHigh   <= wrData[4];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LED_CH; i++) begin
      cfg.duty[i] = actDuty[i];
      cfg.mode[i] = actMode[i*MODE_W +: MODE_W];
    end
  end
  assign cfg.grpDuty     = actGrp;
  assign cfg.stageOnStop = stageOnStop;
  assign cfg.grpBypass   = grpBypass;
  assign cfg.offPolicy   = offPolicy;
  assign cfg.driveHigh   = driveHigh;

endmodule

// File: rtl/led_dimmer_dp.sv
module led_dimmer_dp
  import led_dimmer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  tick_t             ticks,
  input  logic              oeN,
  output logic [LED_CH-1:0] ledData,
  output logic [LED_CH-1:0] ledEn
);

  logic [DUTY_W-1:0] fastCnt, grpCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastCnt <= '0;
      grpCnt  <= '0;
    end else begin
      if (ticks.fastTick) fastCnt <= fastCnt + 1'b1;
      if (ticks.grpTick)  grpCnt  <= grpCnt + 1'b1;
    end
  end

  logic grpGate;
  assign grpGate = cfg.grpBypass || (grpCnt < cfg.grpDuty);

  // pin state while outputs are disabled, shared by all channels
  logic offEn, offData;
  always_comb begin
    unique case (cfg.offPolicy)
      POL_LOW:   begin offEn = 1'b1;          offData = 1'b0; end
      POL_HIORZ: begin offEn = cfg.driveHigh; offData = cfg.driveHigh; end
      default:   begin offEn = 1'b0;          offData = 1'b0; end
    endcase
  end

  for (genvar c = 0; c < LED_CH; c++) begin : g_ch
    logic indOn, src;
    assign indOn = (fastCnt < cfg.duty[c]);
    always_comb begin
      unique case (led_mode_e'(cfg.mode[c]))
        MODE_OFF: src = 1'b0;
        MODE_ON:  src = 1'b1;
        MODE_IND: src = indOn;
        default:  src = indOn && grpGate;
      endcase
    end
    assign ledEn[c]   = !oeN || offEn;
    assign ledData[c] = oeN ? offData : src;
  end

endmodule

// File: rtl/led_dual_dimmer.sv
module led_dual_dimmer
  import led_dimmer_pkg::*;
#(
  parameter int FAST_DIV = 2,
  parameter int GRP_PRE  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DUTY_W-1:0] wrData,
  input  logic              stopStrobe,
  input  logic              oeN,
  output logic [LED_CH-1:0] ledData,
  output logic [LED_CH-1:0] ledEn
);

  cfg_t  cfgBus;
  tick_t tickBus;

  led_dimmer_ctrl #(.FAST_DIV(FAST_DIV), .GRP_PRE(GRP_PRE)) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stopStrobe(stopStrobe), .cfg(cfgBus), .ticks(tickBus)
  );

  led_dimmer_dp dp (
    .clk(clk), .rstN(rstN), .cfg(cfgBus), .ticks(tickBus), .oeN(oeN),
    .ledData(ledData), .ledEn(ledEn)
  );

endmodule

// File: rtl/led_dimmer_checker.sv
module led_dimmer_checker
  import led_dimmer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              oeN,
  input logic              stopStrobe,
  input cfg_t              cfg,
  input logic [LED_CH-1:0] ledData,
  input logic [LED_CH-1:0] ledEn
);

  assert_enabled_pins_R7: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> (ledEn == '1));

  assert_hiz_policy_R7: assert property (@(posedge clk) disable iff (!rstN)
    (oeN && (cfg.offPolicy == POL_Z || cfg.offPolicy == POL_RSVD))
      |-> (ledEn == '0 && ledData == '0));

  assert_staged_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.stageOnStop && !stopStrobe)
      |=> ($stable(cfg.duty) && $stable(cfg.grpDuty) && $stable(cfg.mode)));

  for (genvar c = 0; c < LED_CH; c++) begin : g_chk
    assert_forced_off_R5: assert property (@(posedge clk) disable iff (!rstN)
      (!oeN && cfg.mode[c] == MODE_OFF) |-> !ledData[c]);

    assert_forced_on_R5: assert property (@(posedge clk) disable iff (!rstN)
      (!oeN && cfg.mode[c] == MODE_ON) |-> ledData[c]);

    assert_zero_duty_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!oeN && cfg.mode[c] == MODE_IND && cfg.duty[c] == '0) |-> !ledData[c]);

    assert_group_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!oeN && cfg.mode[c] == MODE_GRP && !cfg.grpBypass && cfg.grpDuty == '0)
        |-> !ledData[c]);
  end

endmodule

bind led_dual_dimmer led_dimmer_checker chk (
  .clk(clk), .rstN(rstN), .oeN(oeN), .stopStrobe(stopStrobe),
  .cfg(cfgBus), .ledData(ledData), .ledEn(ledEn)
);

// File: tb/led_dual_dimmer_test.sv
`timescale 1ns/1ps
module led_dual_dimmer_test;

  localparam int FAST_DIV = 2;
  localparam int GRP_PRE  = 4;
  localparam int FAST_PER = 256 * FAST_DIV;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, stopStrobe = 1'b0, oeN = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] ledData, ledEn;

  always #2.5 clk = ~clk;

  led_dual_dimmer #(.FAST_DIV(FAST_DIV), .GRP_PRE(GRP_PRE)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .stopStrobe(stopStrobe), .oeN(oeN), .ledData(ledData), .ledEn(ledEn)
  );

  int vectors = 0, misses = 0;
  string phase = "R1";
  bit cmpOn = 0, finished = 0;
  int hi [4];

  // behavioural reference
  int mFd, mFc, mGp, mGc, mShdGrp, mActGrp, mShdMode, mActMode;
  int mStage, mBypass, mPol, mDrv;
  int mShd [4];
  int mAct [4];

  always @(posedge clk) begin
    int ft, gt;
    if (!rstN) begin
      mFd = 0; mFc = 0; mGp = 0; mGc = 0;
      mShdGrp = 255; mActGrp = 255; mShdMode = 0; mActMode = 0;
      mStage = 0; mBypass = 0; mPol = 0; mDrv = 0;
      for (int i = 0; i < 4; i++) begin mShd[i] = 0; mAct[i] = 0; end
    end else begin
      ft = (mFd == FAST_DIV - 1);
      gt = ft && (mGp == GRP_PRE - 1);
      mFd = ft ? 0 : mFd + 1;
      if (ft) begin
        mGp = gt ? 0 : mGp + 1;
        mFc = (mFc + 1) % 256;
      end
      if (gt) mGc = (mGc + 1) % 256;
      if (stopStrobe) begin
        for (int i = 0; i < 4; i++) mAct[i] = mShd[i];
        mActGrp = mShdGrp;
        mActMode = mShdMode;
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin
            mStage = wrData[0]; mBypass = wrData[1];
            mPol = int'(wrData[3:2]); mDrv = wrData[4];
          end
          3'd1, 3'd2, 3'd3, 3'd4: begin
            mShd[wrAddr - 1] = wrData;
            if (mStage == 0) mAct[wrAddr - 1] = wrData;
          end
          3'd5: begin
            mShdGrp = wrData;
            if (mStage == 0) mActGrp = wrData;
          end
          3'd7: begin
            mShdMode = wrData;
            if (mStage == 0) mActMode = wrData;
          end
          default: ;
        endcase
      end
    end
  end

  function automatic void modelOut(output logic [3:0] d, output logic [3:0] e);
    for (int c = 0; c < 4; c++) begin
      int m;
      bit s;
      m = (mActMode >> (2 * c)) & 3;
      case (m)
        0: s = 0;
        1: s = 1;
        2: s = (mFc < mAct[c]);
        default: s = (mFc < mAct[c]) && (mBypass != 0 || mGc < mActGrp);
      endcase
      if (!oeN) begin e[c] = 1; d[c] = s; end
      else if (mPol == 0) begin e[c] = 1; d[c] = 0; end
      else if (mPol == 1 && mDrv != 0) begin e[c] = 1; d[c] = 1; end
      else begin e[c] = 0; d[c] = 0; end
    end
  endfunction

  always @(negedge clk) begin
    logic [3:0] md, me;
    if (cmpOn && !finished) begin
      modelOut(md, me);
      vectors++;
      if ({ledData, ledEn} !== {md, me}) begin
        misses++;
        $display("FAIL %s cycle compare: ledData=%b ledEn=%b expected %b %b",
                 phase, ledData, ledEn, md, me);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cyc(1);
    wrEn = 1'b0;
  endtask

  task automatic stop();
    stopStrobe = 1'b1;
    cyc(1);
    stopStrobe = 1'b0;
  endtask

  task automatic countHigh(input int n);
    for (int c = 0; c < 4; c++) hi[c] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) hi[c] += int'(ledData[c]);
    end
    cyc(1);
  endtask

  task automatic expectCounts(input string req, input int e0, input int e1,
                              input int e2, input int e3);
    int exp [4];
    exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
    for (int c = 0; c < 4; c++) check(hi[c] == exp[c], req, hi[c], exp[c]);
  endtask

  task automatic sampleNow();
    @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cmpOn = 1;
    sampleNow();
    check(ledData == 4'b0000, "R1 reset data", int'(ledData), 0);
    check(ledEn == 4'b1111, "R1 reset enable", int'(ledEn), 15);
    cyc(1);

    // R1: reset brightness 00h under mode 10 keeps every pin low
    wr(3'd7, 8'hAA);
    countHigh(FAST_PER);
    expectCounts("R1 reset duty", 0, 0, 0, 0);

    // R2 R3: address map and fast PWM high time
    phase = "R3";
    wr(3'd1, 8'h00); wr(3'd2, 8'h40); wr(3'd3, 8'h80); wr(3'd4, 8'hFF);
    countHigh(FAST_PER);
    expectCounts("R2 R3 high time", 0, 128, 256, 510);

    // R5: forced modes
    phase = "R5";
    wr(3'd7, 8'b01_00_01_00);
    countHigh(FAST_PER);
    expectCounts("R5 forced", 0, FAST_PER, 0, FAST_PER);

    // R4: group gating, compared cycle by cycle over a full group period
    phase = "R4";
    wr(3'd5, 8'h80);
    wr(3'd7, 8'hFF);
    cyc(256 * GRP_PRE * FAST_DIV + 100);
    wr(3'd5, 8'h00);
    countHigh(FAST_PER);
    expectCounts("R4 group zero", 0, 0, 0, 0);

    // R6: bypass makes mode 11 equal to mode 10; group frequency ignored
    phase = "R6";
    wr(3'd0, 8'h02);
    wr(3'd6, 8'h55);
    countHigh(FAST_PER);
    expectCounts("R6 bypass", 0, 128, 256, 510);

    // R7: disabled-output policies
    phase = "R7";
    oeN = 1'b1;
    for (int pol = 0; pol < 4; pol++) begin
      for (int drv = 0; drv < 2; drv++) begin
        int expEn, expD;
        wr(3'd0, 8'((drv << 4) | (pol << 2)));
        sampleNow();
        expEn = (pol == 0) || (pol == 1 && drv == 1);
        expD  = (pol == 1 && drv == 1);
        check(ledEn == (expEn != 0 ? 4'hF : 4'h0), "R7 enable", int'(ledEn), expEn * 15);
        check(ledData == (expD != 0 ? 4'hF : 4'h0), "R7 data", int'(ledData), expD * 15);
        cyc(1);
      end
    end
    oeN = 1'b0;
    cyc(1);

    // R8: staged writes wait for STOP
    phase = "R8";
    wr(3'd0, 8'h00);
    wr(3'd7, 8'hAA);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h10);
    wr(3'd7, 8'h08);
    countHigh(FAST_PER);
    expectCounts("R8 held", 0, 128, 256, 510);
    stop();
    countHigh(FAST_PER);
    expectCounts("R8 after stop", 0, 32, 0, 0);

    // R9: control write applies at once while staging is on
    phase = "R9";
    oeN = 1'b1;
    wr(3'd0, 8'h09);
    sampleNow();
    check(ledEn == 4'h0, "R9 immediate policy", int'(ledEn), 0);
    cyc(1);
    oeN = 1'b0;
    cyc(1);

    // R10: unstaged writes immediate, idle STOP harmless
    phase = "R10";
    wr(3'd0, 8'h00);
    stop();
    countHigh(FAST_PER);
    expectCounts("R10 idle stop", 0, 32, 0, 0);
    wr(3'd2, 8'h60);
    countHigh(FAST_PER);
    expectCounts("R10 immediate", 0, 192, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      misses++;
      vectors++;
      $display("FAIL watchdog %s: actual timeout expected completion", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule